// File: doc/BRIEF.md
# Brake Chopper Hysteresis Controller

This block controls the switch of a DC-bus braking chopper. Each time the ADC offers a new bus-voltage code with a valid strobe, the block compares it with two thresholds. A code above the upper threshold closes the switch, and a code below the lower threshold opens it. A code between the two leaves the switch as it was. This hysteresis lets the resistors bleed off regenerated energy in bursts, which keeps the bus near the upper limit while the motor is braking.

A third, higher threshold raises a drive-disable output that aborts braking. A conduction watchdog guards against a control failure. It counts the clock cycles the switch has been closed within one braking episode. If that total passes a limit sized to a few seconds, it fires a crowbar output that blows the protective fuse. Drive-disable and crowbar both hold until reset. While crowbar is high, the switch is held open.

A braking episode ends after a run of consecutive samples below the lower threshold. The conduction total then returns to zero.

Top module: `brake_chopper_ctrl`

## Requirements
- R1: While reset is low and after its release, `gate_o`, `drive_disable_o`, `crowbar_o` and `brake_cycle_o` are 0 and `band_o` is 0.
- R2: A valid sample with code strictly above ON_CODE (default 3000, at 0.25 V per LSB, about 750 V) sets `gate_o` to 1 from the clock edge that takes the sample. A code equal to ON_CODE does not turn the switch on.
- R3: A valid sample with code strictly below OFF_CODE (default 2800, about 700 V) clears `gate_o` from the edge that takes it. A code equal to OFF_CODE does not turn the switch off.
- R4: A valid sample with code from OFF_CODE to ON_CODE inclusive leaves `gate_o` unchanged.
- R5: While `sample_valid_i` is 0, changes on `bus_code_i` affect no output except through the watchdog time base.
- R6: A valid sample with code strictly above ABORT_CODE (default 3240, about 810 V) sets `drive_disable_o`, which then holds at 1 until reset. A code equal to ABORT_CODE does not set it.
- R7: The watchdog counts every clock cycle in which `gate_o` is 1 within one braking episode. At the edge where `gate_o` is 1 and the count already equals WDOG_LIMIT, `crowbar_o` rises and `gate_o` falls.
- R8: Once `crowbar_o` is 1 it holds until reset, and `gate_o` stays 0 whatever samples arrive.
- R9: After IDLE_SAMPLES consecutive valid samples below OFF_CODE, the conduction count returns to 0 one edge later. `brake_cycle_o` is 1 exactly while the count is non-zero.
- R10: `band_o` holds the class of the last valid sample: 0 below OFF_CODE, 1 from OFF_CODE to ON_CODE, 2 above ON_CODE up to ABORT_CODE, 3 above ABORT_CODE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_valid_i | input | 1 | Strobe marking a new bus-voltage code |
| bus_code_i | input | CODE_W | Unsigned bus-voltage code, 0.25 V per LSB |
| gate_o | output | 1 | Chopper switch drive, 1 = conducting |
| drive_disable_o | output | 1 | Sticky overvoltage abort to the drive |
| crowbar_o | output | 1 | Sticky crowbar fire on excess conduction |
| band_o | output | 2 | Voltage class of the last valid sample |
| brake_cycle_o | output | 1 | Conduction accumulated in the current episode |

## Verification
Codes are applied right at each threshold and one LSB past it. This separates strict from inclusive comparisons for the on, off and abort levels. Samples inside the band, given after both an on and an off transition, show that the band holds state and does not force it. Code changes without the strobe show that the gate responds to samples only. Two bursts of conduction, each under the limit but together over it, are run twice. In one run they are separated by a full run of low samples and must not trip. In the other they are separated by too short a run and must trip at the exact cycle. Later high samples then test that the crowbar holds the switch open.

// File: rtl/brake_chopper_pkg.sv
package brake_chopper_pkg;
  typedef enum logic [1:0] {
    BAND_LOW   = 2'd0,
    BAND_HOLD  = 2'd1,
    BAND_HIGH  = 2'd2,
    BAND_ABORT = 2'd3
  } band_e;
endpackage

// File: rtl/bc_band_monitor.sv
module bc_band_monitor
  import brake_chopper_pkg::*;
#(
  parameter int CODE_W     = 12,
  parameter int ON_CODE    = 3000,
  parameter int OFF_CODE   = 2800,
  parameter int ABORT_CODE = 3240
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              above_on_o,
  output logic              below_off_o,
  output band_e             band_o,
  output logic              disable_o
);
  localparam logic [CODE_W-1:0] OnLvl    = CODE_W'(ON_CODE);
  localparam logic [CODE_W-1:0] OffLvl   = CODE_W'(OFF_CODE);
  localparam logic [CODE_W-1:0] AbortLvl = CODE_W'(ABORT_CODE);

  logic  over_abort;
  band_e band_d;
  band_e band_q;
  logic  dis_q;

  assign above_on_o  = code_i > OnLvl;
  assign below_off_o = code_i < OffLvl;
  assign over_abort  = code_i > AbortLvl;

  always_comb begin
    if (over_abort)       band_d = BAND_ABORT;
    else if (above_on_o)  band_d = BAND_HIGH;
    else if (below_off_o) band_d = BAND_LOW;
    else                  band_d = BAND_HOLD;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      band_q <= BAND_LOW;
      dis_q  <= 1'b0;
    end else if (valid_i) begin
      band_q <= band_d;
      if (over_abort) dis_q <= 1'b1;
    end
  end

  assign band_o    = band_q;
  assign disable_o = dis_q;

  // R6: sticky abort
  a_r6_disable_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dis_q |=> dis_q);
  // R6: abort code sets disable
  a_r6_abort_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && over_abort) |=> dis_q);
  // R10: band held without strobe
  a_r10_band_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(band_q));
endmodule

// File: rtl/bc_gate_hyst.sv
module bc_gate_hyst (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic above_on_i,
  input  logic below_off_i,
  input  logic trip_i,
  input  logic crowbar_i,
  output logic gate_o
);
  logic gate_q;
  logic force_off;

  assign force_off = trip_i | crowbar_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     gate_q <= 1'b0;
    else if (force_off)              gate_q <= 1'b0;
    else if (valid_i && above_on_i)  gate_q <= 1'b1;
    else if (valid_i && below_off_i) gate_q <= 1'b0;
  end

  assign gate_o = gate_q;

  // R8: switch open while crowbar is fired
  a_r8_gate_off_crowbar: assert property (@(posedge clk_i) disable iff (!rst_ni)
    crowbar_i |-> !gate_q);
  // R2: high sample closes switch
  a_r2_turn_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && above_on_i && !force_off) |=> gate_q);
  // R3: low sample opens switch
  a_r3_turn_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && below_off_i) |=> !gate_q);
  // R4 / R5: no change without a qualifying sample
  a_r5_gate_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!force_off && !(valid_i && (above_on_i || below_off_i))) |=> gate_q == $past(gate_q));
endmodule

// File: rtl/bc_cond_watchdog.sv
module bc_cond_watchdog #(
  parameter int WDOG_LIMIT   = 1_000_000_000,
  parameter int IDLE_SAMPLES = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic below_off_i,
  input  logic gate_i,
  output logic trip_o,
  output logic crowbar_o,
  output logic active_o
);
  localparam int CntW  = $clog2(WDOG_LIMIT + 1);
  localparam int IdleW = $clog2(IDLE_SAMPLES + 1);
  localparam logic [CntW-1:0]  CntMax  = CntW'(WDOG_LIMIT);
  localparam logic [IdleW-1:0] IdleMax = IdleW'(IDLE_SAMPLES);

  logic [CntW-1:0]  cnt_q;
  logic [IdleW-1:0] idle_q;
  logic             crow_q;
  logic             idle_full;
  logic             at_max;

  assign at_max    = cnt_q == CntMax;
  assign idle_full = idle_q == IdleMax;
  assign trip_o    = gate_i & at_max;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (gate_i) begin
      if (!at_max) cnt_q <= cnt_q + 1'b1;
    end else if (idle_full) begin
      cnt_q <= '0;
    end
  end

  // consecutive low samples mark the end of a braking episode
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idle_q <= '0;
    end else if (valid_i) begin
      if (!below_off_i)    idle_q <= '0;
      else if (!idle_full) idle_q <= idle_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     crow_q <= 1'b0;
    else if (trip_o) crow_q <= 1'b1;
  end

  assign crowbar_o = crow_q;
  assign active_o  = cnt_q != '0;

  // R8: crowbar latch
  a_r8_crowbar_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    crow_q |=> crow_q);
  // R7: count never exceeds limit
  a_r7_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CntMax);
  // R7: conduction at limit fires crowbar
  a_r7_trip_fires: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_i && at_max) |=> crow_q);
  // R9: idle episode clears count
  a_r9_idle_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!gate_i && idle_full) |=> cnt_q == '0);
endmodule

// File: rtl/brake_chopper_ctrl.sv
module brake_chopper_ctrl
  import brake_chopper_pkg::*;
#(
  parameter int CODE_W       = 12,
  parameter int ON_CODE      = 3000,
  parameter int OFF_CODE     = 2800,
  parameter int ABORT_CODE   = 3240,
  parameter int WDOG_LIMIT   = 1_000_000_000,
  parameter int IDLE_SAMPLES = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sample_valid_i,
  input  logic [CODE_W-1:0] bus_code_i,
  output logic              gate_o,
  output logic              drive_disable_o,
  output logic              crowbar_o,
  output logic [1:0]        band_o,
  output logic              brake_cycle_o
);
  logic  above_on;
  logic  below_off;
  logic  trip;
  logic  gate;
  logic  crowbar;
  band_e band;

  bc_band_monitor #(
    .CODE_W    (CODE_W),
    .ON_CODE   (ON_CODE),
    .OFF_CODE  (OFF_CODE),
    .ABORT_CODE(ABORT_CODE)
  ) u_band (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (sample_valid_i),
    .code_i     (bus_code_i),
    .above_on_o (above_on),
    .below_off_o(below_off),
    .band_o     (band),
    .disable_o  (drive_disable_o)
  );

  bc_gate_hyst u_gate (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (sample_valid_i),
    .above_on_i (above_on),
    .below_off_i(below_off),
    .trip_i     (trip),
    .crowbar_i  (crowbar),
    .gate_o     (gate)
  );

  bc_cond_watchdog #(
    .WDOG_LIMIT  (WDOG_LIMIT),
    .IDLE_SAMPLES(IDLE_SAMPLES)
  ) u_wdog (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (sample_valid_i),
    .below_off_i(below_off),
    .gate_i     (gate),
    .trip_o     (trip),
    .crowbar_o  (crowbar),
    .active_o   (brake_cycle_o)
  );

  assign gate_o    = gate;
  assign crowbar_o = crowbar;
  assign band_o    = band;
endmodule

// File: tb/tb_brake_chopper_ctrl.sv
module tb_brake_chopper_ctrl;
  localparam int LIMIT = 40;
  localparam int IDLE  = 4;

  typedef struct {
    logic       gate;
    logic       dis;
    logic       crow;
    logic [1:0] band;
    logic       cyc;
    string      tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [11:0] code = '0;
  logic        gate_o, dis_o, crow_o, cyc_o;
  logic [1:0]  band_o;

  int checks = 0;
  int failures = 0;
  exp_t sb[$];

  int   m_cnt = 0, m_idle = 0;
  logic m_gate = 0, m_crow = 0, m_dis = 0;
  logic [1:0] m_band = 0;

  always #2.5 clk = ~clk;

  brake_chopper_ctrl #(.WDOG_LIMIT(LIMIT), .IDLE_SAMPLES(IDLE)) dut (
    .clk_i(clk), .rst_ni(rst_n), .sample_valid_i(valid), .bus_code_i(code),
    .gate_o(gate_o), .drive_disable_o(dis_o), .crowbar_o(crow_o),
    .band_o(band_o), .brake_cycle_o(cyc_o)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // driver: one clock of stimulus, expected post-edge state into the scoreboard
  task automatic step(input logic v, input int c, input string tag);
    logic trip;
    exp_t e;
    @(negedge clk);
    valid = v;
    code  = 12'(c);
    trip  = m_gate && (m_cnt == LIMIT);
    if (m_gate) begin
      if (m_cnt != LIMIT) m_cnt++;
    end else if (m_idle == IDLE) m_cnt = 0;
    if (trip || m_crow)      m_gate = 0;
    else if (v && c > 3000)  m_gate = 1;
    else if (v && c < 2800)  m_gate = 0;
    if (trip) m_crow = 1;
    if (v) begin
      if (c < 2800) begin
        if (m_idle != IDLE) m_idle++;
      end else m_idle = 0;
      if (c > 3240) m_dis = 1;
      m_band = (c > 3240) ? 2'd3 : (c > 3000) ? 2'd2 : (c < 2800) ? 2'd0 : 2'd1;
    end
    e.gate = m_gate; e.dis = m_dis; e.crow = m_crow;
    e.band = m_band; e.cyc = (m_cnt != 0); e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic hold(input int n, input int c, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, c, tag);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        chk(e.tag, "gate_o", gate_o, e.gate);
        chk(e.tag, "drive_disable_o", dis_o, e.dis);
        chk(e.tag, "crowbar_o", crow_o, e.crow);
        chk(e.tag, "band_o", band_o, e.band);
        chk(e.tag, "brake_cycle_o", cyc_o, e.cyc);
      end
    end
  end

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "gate_o", gate_o, 0);
        chk("R1", "drive_disable_o", dis_o, 0);
        chk("R1", "crowbar_o", crow_o, 0);
        chk("R1", "band_o", band_o, 0);
        chk("R1", "brake_cycle_o", cyc_o, 0);
        rst_n = 1'b1;
        step(1, 2900, "R4");
        step(1, 3000, "R2");
        step(1, 3001, "R2");
        hold(3, 2000, "R5");
        step(1, 2900, "R4");
        step(1, 2800, "R3");
        step(1, 2799, "R3");
        hold(2, 3500, "R5");
        step(1, 3100, "R10");
        step(1, 3240, "R6");
        step(1, 3241, "R6");
        step(1, 2000, "R6");
        step(1, 3000, "R10");
        // R9: two bursts separated by a full idle run
        for (int i = 0; i < IDLE; i++) step(1, 2000, "R9");
        hold(2, 0, "R9");
        step(1, 3100, "R9");
        hold(28, 0, "R9");
        for (int i = 0; i < IDLE; i++) step(1, 2500, "R9");
        hold(2, 0, "R9");
        step(1, 3100, "R9");
        hold(28, 0, "R9");
        for (int i = 0; i < IDLE; i++) step(1, 2500, "R9");
        hold(2, 0, "R9");
        // R7: bursts with a too-short idle run accumulate and trip
        step(1, 3100, "R7");
        hold(20, 0, "R7");
        for (int i = 0; i < IDLE - 1; i++) step(1, 2500, "R7");
        step(1, 3100, "R7");
        hold(30, 0, "R7");
        // R8: crowbar holds, switch stays open
        step(1, 3100, "R8");
        step(1, 2900, "R8");
        for (int i = 0; i < IDLE + 1; i++) step(1, 2000, "R8");
        step(1, 3200, "R8");
        hold(3, 0, "R8");
        while (sb.size() > 0) @(negedge clk);
        @(negedge clk);
      end
      begin
        repeat (20000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog timeout actual=hung expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule